// File: doc/BRIEF.md
# DRAM Cycle Controller with Late Abort

This block drives the row strobe, column strobe, write enable, multiplexed address and ready handshake for a DRAM array on a processor's data bus. A request is taken on a rising clock edge, and the row strobe falls on the falling edge in the middle of that same first bus clock. The controller does not wait for the second clock. A burst request is served as page-mode column cycles, one word per clock, with the column address counting up inside the open page.

The processor may cancel a cycle with a bus-invalid input, but that input is only trustworthy in the second half of the first clock, when the row strobe is already low. The controller captures the input at the end of the first clock and marks the whole cycle as cancelled. It then keeps the column strobe, write enable and ready inactive for every beat. The row strobe stays low for the same number of clocks as an uncancelled cycle of the same kind, and afterwards the normal precharge gap follows. When a write comes straight after a completed read, the start of the write is held off by one clock so the memory's read drivers can release the shared data lines.

Top module: `dram_abort_ctrl`

## Requirements
- R1: While reset is held, ras_n_o, cas_n_o and we_n_o are 1 and rdy_o is 0.
- R2: A request sampled high on a rising edge while idle makes ras_n_o go low on the next falling edge. During that first clock, ma_o carries the row field, which is bits [2*MA_W-1:MA_W] of addr_i, and cas_n_o stays high.
- R3: From the first rising edge after ras_n_o falls, ma_o carries the column. The column is bits [MA_W-1:0] of addr_i plus the beat index, taken modulo 2^MA_W, so it wraps inside the page.
- R4: When burst_i is 1 at acceptance, the cycle has BURST_LEN consecutive clocks with cas_n_o low and rdy_o high. cas_n_o is never low while ras_n_o is high.
- R5: When burst_i is 0 at acceptance, the cycle has exactly one such clock.
- R6: If bus_inv_i is 1 at the rising edge that ends the first clock, cas_n_o, we_n_o and rdy_o stay inactive for the whole cycle. The next cycle is not affected.
- R7: In a cancelled cycle, ras_n_o stays low for the same number of clocks as in a normal cycle of the same length: beats plus one.
- R8: Between two cycles, ras_n_o stays high for at least PRECH_CLKS (2) clocks, and this also applies after a cancelled cycle. A waiting request starts with exactly that gap.
- R9: A write (rd_i = 0) that follows a completed read starts one clock later, giving a gap of PRECH_CLKS+1 clocks.
- R10: we_n_o is low in exactly the beats of an uncancelled write and stays high during reads.
- R11: bus_inv_i asserted at any time other than the end of the first clock has no effect on the cycle.
- R12: A cancelled read does not count as a read for R9, so a write after it starts with the plain PRECH_CLKS gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Cycle request, held until the row strobe falls |
| rd_i | input | 1 | 1 = read, 0 = write |
| burst_i | input | 1 | 1 = BURST_LEN-word page-mode burst |
| addr_i | input | 2*MA_W | Row field in the upper half, column field in the lower half |
| bus_inv_i | input | 1 | Cancel the current cycle, sampled at the end of the first clock |
| rdy_o | output | 1 | One word transferred this clock |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ma_o | output | MA_W | Multiplexed DRAM address |

## Verification
The critical overlap is a late cancel during a cycle that already has its row strobe active. In that case the cancel capture and the row-strobe timing both act on the same beats. The bench raises bus_inv_i just after the row strobe falls on burst and single cycles, for both reads and writes. It then checks that no column strobe or ready appears, that the row strobe stays low exactly as long as in the uncancelled version, and that the following cycle keeps the normal precharge gap and suffers no extra turnaround. A second overlap occurs when a pending request meets the end of precharge and the turnaround rule at once. The bench provokes it by arming the next request during the current cycle's beats and then measuring the number of high row-strobe clocks before the next fall.

// File: rtl/dac_pkg.sv
package dac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_FIRST,
    ST_BEAT,
    ST_PRECH
  } dac_state_e;
endpackage

// File: rtl/dac_seq.sv
module dac_seq
  import dac_pkg::*;
#(
  parameter int BURST_LEN  = 4,
  parameter int PRECH_CLKS = 2,
  localparam int BW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1,
  localparam int PW = (PRECH_CLKS > 2) ? $clog2(PRECH_CLKS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          rd_i,
  input  logic          burst_i,
  input  logic          bus_inv_i,
  output dac_state_e    st_o,
  output logic [BW-1:0] beat_o,
  output logic          accept_o,
  output logic          ras_want_o,
  output logic          cas_act_o,
  output logic          we_act_o
);
  localparam logic [BW-1:0] LAST_BURST = BW'(BURST_LEN - 1);
  localparam logic [PW-1:0] PRECH_LOAD = PW'(PRECH_CLKS - 2);

  dac_state_e    st_q, st_n;
  logic [BW-1:0] beat_q, beat_n;
  logic [PW-1:0] prch_q, prch_n;
  logic          abort_q, abort_n;
  logic          rd_q, rd_n;
  logic          burst_q, burst_n;
  logic          lastrd_q, lastrd_n;
  logic [BW-1:0] last_beat;

  assign last_beat = burst_q ? LAST_BURST : '0;

  always_comb begin
    st_n     = st_q;
    beat_n   = beat_q;
    prch_n   = prch_q;
    abort_n  = abort_q;
    rd_n     = rd_q;
    burst_n  = burst_q;
    lastrd_n = lastrd_q;
    accept_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_i) begin
          accept_o = 1'b1;
          rd_n     = rd_i;
          burst_n  = burst_i;
          st_n     = (!rd_i && lastrd_q) ? ST_TURN : ST_FIRST;
        end
      end
      ST_TURN: st_n = ST_FIRST;
      ST_FIRST: begin
        abort_n = bus_inv_i;
        beat_n  = '0;
        st_n    = ST_BEAT;
      end
      ST_BEAT: begin
        if (beat_q == last_beat) begin
          st_n     = ST_PRECH;
          prch_n   = PRECH_LOAD;
          abort_n  = 1'b0;
          lastrd_n = rd_q && !abort_q;
        end else begin
          beat_n = beat_q + 1'b1;
        end
      end
      ST_PRECH: begin
        if (prch_q == '0) st_n = ST_IDLE;
        else              prch_n = prch_q - 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      beat_q   <= '0;
      prch_q   <= '0;
      abort_q  <= 1'b0;
      rd_q     <= 1'b1;
      burst_q  <= 1'b0;
      lastrd_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      beat_q   <= beat_n;
      prch_q   <= prch_n;
      abort_q  <= abort_n;
      rd_q     <= rd_n;
      burst_q  <= burst_n;
      lastrd_q <= lastrd_n;
    end
  end

  assign st_o       = st_q;
  assign beat_o     = beat_q;
  assign ras_want_o = (st_q == ST_FIRST) || (st_q == ST_BEAT);
  assign cas_act_o  = (st_q == ST_BEAT) && !abort_q;
  assign we_act_o   = cas_act_o && !rd_q;

  AST_TURN_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && req_i && !rd_i && lastrd_q) |=> (st_q == ST_TURN)) // R9
    else $error("write after read skipped turnaround");

  AST_BEAT_FOLLOWS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FIRST) |=> (st_q == ST_BEAT && beat_q == '0)) // R7
    else $error("first clock not followed by beat 0");
endmodule

// File: rtl/dac_ras_drv.sv
module dac_ras_drv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ras_want_i,
  output logic ras_n_o
);
  logic ras_n_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ras_n_q <= 1'b1;
    else         ras_n_q <= !ras_want_i;
  end

  assign ras_n_o = ras_n_q;
endmodule

// File: rtl/dac_addr_mux.sv
module dac_addr_mux
  import dac_pkg::*;
#(
  parameter int MA_W = 10,
  parameter int BW   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic [2*MA_W-1:0] addr_i,
  input  dac_state_e      st_i,
  input  logic [BW-1:0]   beat_i,
  output logic [MA_W-1:0] ma_o
);
  logic [MA_W-1:0] row_q, row_n;
  logic [MA_W-1:0] col_q, col_n;

  always_comb begin
    row_n = row_q;
    col_n = col_q;
    if (accept_i) begin
      row_n = addr_i[2*MA_W-1:MA_W];
      col_n = addr_i[MA_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      row_q <= row_n;
      col_q <= col_n;
    end
  end

  assign ma_o = (st_i == ST_BEAT) ? (col_q + MA_W'(beat_i)) : row_q;
endmodule

// File: rtl/dram_abort_ctrl.sv
module dram_abort_ctrl
  import dac_pkg::*;
#(
  parameter int MA_W       = 10,
  parameter int BURST_LEN  = 4,
  parameter int PRECH_CLKS = 2,
  localparam int BW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1,
  localparam int HW = $clog2(PRECH_CLKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              rd_i,
  input  logic              burst_i,
  input  logic [2*MA_W-1:0] addr_i,
  input  logic              bus_inv_i,
  output logic              rdy_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [MA_W-1:0]   ma_o
);
  dac_state_e    st;
  logic [BW-1:0] beat;
  logic          accept, ras_want, cas_act, we_act;

  dac_seq #(.BURST_LEN(BURST_LEN), .PRECH_CLKS(PRECH_CLKS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .rd_i(rd_i),
    .burst_i(burst_i), .bus_inv_i(bus_inv_i), .st_o(st), .beat_o(beat),
    .accept_o(accept), .ras_want_o(ras_want), .cas_act_o(cas_act),
    .we_act_o(we_act)
  );

  dac_ras_drv u_ras (
    .clk_i(clk_i), .rst_ni(rst_ni), .ras_want_i(ras_want), .ras_n_o(ras_n_o)
  );

  dac_addr_mux #(.MA_W(MA_W), .BW(BW)) u_mux (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .addr_i(addr_i),
    .st_i(st), .beat_i(beat), .ma_o(ma_o)
  );

  assign cas_n_o = !cas_act;
  assign rdy_o   = cas_act;
  assign we_n_o  = !we_act;

  // rising-edge count of row-strobe-high clocks, saturating, for the gap check
  logic [HW-1:0] hi_q, hi_n;
  always_comb begin
    hi_n = hi_q;
    if (!ras_n_o)                     hi_n = '0;
    else if (hi_q != HW'(PRECH_CLKS)) hi_n = hi_q + 1'b1;
  end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_q <= HW'(PRECH_CLKS);
    else         hi_q <= hi_n;
  end

  AST_PRECH_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (hi_q >= HW'(PRECH_CLKS))) // R8
    else $error("row precharge too short");

  AST_CAS_INSIDE_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n_o |-> !ras_n_o) // R4
    else $error("column strobe without row strobe");

  AST_ABORT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st == ST_FIRST) && $past(bus_inv_i)) |-> (cas_n_o && !rdy_o && we_n_o)) // R6
    else $error("cancelled cycle produced a strobe");

  AST_WE_WITH_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> !cas_n_o) // R10
    else $error("write enable outside a column beat");
endmodule

// File: tb/dram_abort_ctrl_tb_top.sv
module dram_abort_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MA_W  = 10;
  localparam int BLEN  = 4;
  localparam int PRECH = 2;

  logic clk, rst_n, req, rd, burst, bus_inv;
  logic [2*MA_W-1:0] addr;
  logic rdy, ras_n, cas_n, we_n;
  logic [MA_W-1:0] ma;

  int checks, errors, hi_run;
  bit nxt_v, nxt_rd, nxt_burst;
  logic [MA_W-1:0] nxt_row, nxt_col;

  dram_abort_ctrl #(.MA_W(MA_W), .BURST_LEN(BLEN), .PRECH_CLKS(PRECH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rd_i(rd), .burst_i(burst),
    .addr_i(addr), .bus_inv_i(bus_inv), .rdy_o(rdy), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .ma_o(ma)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #2;
    if (ras_n) hi_run++;
    else       hi_run = 0;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic arm(input logic [MA_W-1:0] r, c, input bit r_w, b);
    req = 1'b1; rd = r_w; burst = b; addr = {r, c};
  endtask

  task automatic queue_next(input logic [MA_W-1:0] r, c, input bit r_w, b);
    nxt_v = 1'b1; nxt_row = r; nxt_col = c; nxt_rd = r_w; nxt_burst = b;
  endtask

  // request already armed; wait for start, apply cancel, collect beats
  task automatic xfer(input logic [MA_W-1:0] r, c, input bit r_w, b, ab, late,
                      input int exp_gap);
    int beats, low, ncas, nrdy, nwe, gap, guard;
    bit seen;
    beats = b ? BLEN : 1;
    seen = 1'b0; guard = 0; gap = 0;
    while (!seen && guard < 100) begin
      @(negedge clk); #1;
      if (!ras_n) begin seen = 1'b1; gap = hi_run; end
      guard++;
    end
    if (!seen) begin
      chk("R2 watchdog start", 0, 1);
      return;
    end
    req = 1'b0;
    bus_inv = ab;
    chk("R2 row on mux", int'(ma), int'(r));
    chk("R2 no cas in first clock", int'(cas_n), 1);
    if (exp_gap >= 0)
      chk(exp_gap > PRECH ? "R9 turnaround gap" : "R8 precharge gap", gap, exp_gap);
    low = 0; ncas = 0; nrdy = 0; nwe = 0; guard = 0;
    seen = 1'b0;
    while (!seen && guard < 100) begin
      @(posedge clk); #2;
      if (guard == 0) begin
        bus_inv = late;
        if (nxt_v) begin arm(nxt_row, nxt_col, nxt_rd, nxt_burst); nxt_v = 1'b0; end
      end
      if (ras_n) seen = 1'b1;
      else begin
        low++;
        if (!cas_n) ncas++;
        if (!we_n) nwe++;
        if (rdy) begin
          chk("R3 column address", int'(ma), int'(MA_W'(c + MA_W'(nrdy))));
          nrdy++;
        end
      end
      guard++;
    end
    bus_inv = 1'b0;
    if (!seen) chk("R7 watchdog end", 0, 1);
    chk(ab ? "R7 cancelled ras length" : (b ? "R4 ras length" : "R5 ras length"),
        low, beats + 1);
    chk(ab ? "R6 cas count" : (late ? "R11 cas count" : (b ? "R4 cas count" : "R5 cas count")),
        ncas, ab ? 0 : beats);
    chk(ab ? "R6 rdy count" : "R4 rdy count", nrdy, ab ? 0 : beats);
    chk("R10 we count", nwe, (ab || r_w) ? 0 : beats);
  endtask

  task automatic t_reset();
    req = 0; rd = 1; burst = 0; bus_inv = 0; addr = '0; nxt_v = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 ras_n", int'(ras_n), 1);
    chk("R1 cas_n", int'(cas_n), 1);
    chk("R1 we_n", int'(we_n), 1);
    chk("R1 rdy", int'(rdy), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_single_read();
    @(negedge clk); arm(10'd5, 10'd9, 1, 0);
    xfer(10'd5, 10'd9, 1, 0, 0, 0, -1);
  endtask

  task automatic t_burst_wrap();
    @(negedge clk); arm(10'd33, 10'h3FE, 1, 1);
    queue_next(10'd34, 10'd7, 1, 0);
    xfer(10'd33, 10'h3FE, 1, 1, 0, 0, -1);
    xfer(10'd34, 10'd7, 1, 0, 0, 0, PRECH);
  endtask

  task automatic t_turnaround();
    @(negedge clk); arm(10'd2, 10'd16, 1, 1);
    queue_next(10'd3, 10'd20, 0, 1);
    xfer(10'd2, 10'd16, 1, 1, 0, 0, -1);
    xfer(10'd3, 10'd20, 0, 1, 0, 0, PRECH + 1);
  endtask

  task automatic t_abort_read();
    @(negedge clk); arm(10'd77, 10'd40, 1, 1);
    queue_next(10'd78, 10'd41, 0, 0);
    xfer(10'd77, 10'd40, 1, 1, 1, 0, -1);
    xfer(10'd78, 10'd41, 0, 0, 0, 0, PRECH);   // R12 no turnaround after cancelled read
  endtask

  task automatic t_abort_write();
    @(negedge clk); arm(10'd90, 10'd1, 0, 0);
    queue_next(10'd91, 10'd2, 1, 1);
    xfer(10'd90, 10'd1, 0, 0, 1, 0, -1);
    xfer(10'd91, 10'd2, 1, 1, 0, 0, PRECH);    // R6 next cycle unaffected
  endtask

  task automatic t_late_inv();
    @(negedge clk); arm(10'd12, 10'd100, 1, 1);
    xfer(10'd12, 10'd100, 1, 1, 0, 1, -1);     // R11
  endtask

  task automatic t_write_write();
    @(negedge clk); arm(10'd300, 10'd8, 0, 1);
    queue_next(10'd301, 10'd12, 0, 1);
    xfer(10'd300, 10'd8, 0, 1, 0, 0, -1);
    xfer(10'd301, 10'd12, 0, 1, 0, 0, PRECH);
  endtask

  initial begin
    checks = 0; errors = 0; hi_run = 0;
    fork
      begin
        t_reset();
        t_single_read();
        t_burst_wrap();
        t_turnaround();
        t_abort_read();
        t_abort_write();
        t_late_inv();
        t_write_write();
      end
      begin
        repeat (20000) @(posedge clk);
        chk("watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule